// File: doc/BRIEF.md
# PRBS7 Bit Error Rate Tester

This block checks one line of a multi-line link at a time. A start strobe latches a lane index, reseeds a seven-stage pseudo-random generator and opens a test run. During the run the block drives the pattern as a complementary pair and enables only the chosen lane of a routing multiplexer. It then compares each returned bit with the bit sent a fixed number of cycles earlier and counts every mismatch in a saturating counter.

The link's round-trip delay is set by a latency parameter. A run sends a whole number of 127-bit pattern periods. When the last compare has been made, the block raises a done flag and holds the count on a parallel output. During the first counter-width cycles of done it also shifts the count out serially, most significant bit first, so that a narrow readout path can collect it. The host turns the count into an error rate. The intended line rate is 320 MHz.

Top module: `prbs_bert`

## Requirements
- R1: The pattern comes from a 7-bit generator with feedback taps x^7 + x^6 + 1. It is reseeded to SEED (default 7'h7F) at each start, and its state is never all-zero. The generator's top bit is the sent bit. The first sent bit appears in the cycle after the start edge and is bit 6 of SEED. The sequence repeats every 127 bits.
- R2: The negative leg txN_o is always the inverse of txP_o. txP_o is 0 whenever no pattern bit is being sent.
- R3: Run cycles are numbered k = 0, 1, 2, ... from the cycle after the start edge. The run lasts TOTAL = 127*PASSES + LATENCY cycles, and pattern bit k is sent in run cycle k for k < 127*PASSES. For the whole run laneEn_o has the single bit set whose position equals the lane index latched at start. Outside a run laneEn_o is zero.
- R4: A change of laneSel_i during a run has no effect on laneEn_o until the next start.
- R5: For k >= LATENCY, rxBit_i in run cycle k is compared with pattern bit k-LATENCY, and a mismatch adds one to the count. rxBit_i is ignored in run cycles k < LATENCY and outside a run.
- R6: Each start clears the count to zero in the next cycle. The count stops at 255 and never wraps.
- R7: done_o rises in the cycle after the last compare, which is run cycle TOTAL-1. It stays high, with errCnt_o unchanged, until the next start. done_o is low during a run.
- R8: In the first 8 cycles of done, serValid_o is high and serBit_o carries the final count, most significant bit first. serValid_o is low at all other times.
- R9: A start during a run, or after one, abandons that run and begins a fresh one.
- R10: After reset: txP_o=0, txN_o=1, laneEn_o=0, done_o=0, serValid_o=0, errCnt_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that begins a run |
| laneSel_i | input | SEL_W (4) | Index of the lane to test, latched at start |
| rxBit_i | input | 1 | Bit returned from the lane under test |
| txP_o | output | 1 | Pattern bit, positive leg |
| txN_o | output | 1 | Inverted pattern bit, negative leg |
| laneEn_o | output | LANES (16) | One-hot lane enable for the routing multiplexer |
| done_o | output | 1 | Run complete; count is final |
| errCnt_o | output | CNT_W (8) | Saturating mismatch count |
| serBit_o | output | 1 | Serial count bit, most significant first |
| serValid_o | output | 1 | serBit_o carries a count bit |

## Verification
The assertions check the cycle-level rules on every clock: the generator never reaches zero, the lane enable is at most one-hot and stays fixed through a run, and the count is cleared at start. They also check that the count only ever holds or steps by one, and that it is frozen with the lane disabled while done is high. The bench scenarios show what a property cannot: the exact pattern bits and their 127-bit period, and that compares line up with the latency parameter. The scenarios also cover early-cycle received bits being ignored, the final count for known injected error patterns including saturation, the serial order of the count, and a restart in the middle of a run.

// File: rtl/prbs_bert_pkg.sv
package prbs_bert_pkg;

  localparam int unsigned PRBS_ORDER  = 7;
  localparam int unsigned PRBS_PERIOD = (1 << PRBS_ORDER) - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } bertState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // reseed, clear count, latch lane
    logic txEn;     // a pattern bit is being sent this cycle
    logic cmpEn;    // returned bit is compared this cycle
    logic lastCmp;  // final compare of the run
    logic shiftEn;  // serial readout cycle
    logic laneOn;   // lane enable active
  } bertCtrl_t;

endpackage

// File: rtl/bert_ctrl.sv
module bert_ctrl
  import prbs_bert_pkg::*;
#(
  parameter int unsigned TOTAL_BITS = 127,
  parameter int unsigned LATENCY    = 2,
  parameter int unsigned CNT_W      = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  output bertCtrl_t ctrl_o,
  output logic      done_o
);

  localparam int unsigned RUN_LEN = TOTAL_BITS + LATENCY;
  localparam int unsigned K_W     = $clog2(RUN_LEN + 1);
  localparam int unsigned B_W     = $clog2(CNT_W + 1);

  bertState_e      state, stateNext;
  logic [K_W-1:0]  runIdx;
  logic [B_W-1:0]  bitIdx;
  logic            inRun, runEnd, shiftEnd;

  assign inRun    = (state == ST_RUN);
  assign runEnd   = inRun && (runIdx == K_W'(RUN_LEN - 1));
  assign shiftEnd = (state == ST_SHIFT) && (bitIdx == B_W'(CNT_W - 1));

  always_comb begin
    stateNext = state;
    if (start_i) begin
      stateNext = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN:   if (runEnd)   stateNext = ST_SHIFT;
        ST_SHIFT: if (shiftEnd) stateNext = ST_DONE;
        default:  stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      runIdx <= '0;
      bitIdx <= '0;
    end else begin
      state <= stateNext;
      if (start_i)    runIdx <= '0;
      else if (inRun) runIdx <= runIdx + 1'b1;
      if (state == ST_SHIFT) bitIdx <= bitIdx + 1'b1;
      else                   bitIdx <= '0;
    end
  end

  always_comb begin
    ctrl_o.load    = start_i;
    ctrl_o.txEn    = inRun && (runIdx < K_W'(TOTAL_BITS));
    ctrl_o.cmpEn   = inRun && !start_i && (runIdx >= K_W'(LATENCY));
    ctrl_o.lastCmp = runEnd && !start_i;
    ctrl_o.shiftEn = (state == ST_SHIFT);
    ctrl_o.laneOn  = inRun;
  end

  assign done_o = (state == ST_SHIFT) || (state == ST_DONE);

endmodule

// File: rtl/bert_datapath.sv
module bert_datapath
  import prbs_bert_pkg::*;
#(
  parameter int unsigned           LANES   = 16,
  parameter int unsigned           SEL_W   = 4,
  parameter int unsigned           CNT_W   = 8,
  parameter int unsigned           LATENCY = 2,
  parameter logic [PRBS_ORDER-1:0] SEED    = 7'h7F
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  bertCtrl_t             ctrl_i,
  input  logic [SEL_W-1:0]      laneSel_i,
  input  logic                  rxBit_i,
  output logic                  txBit_o,
  output logic [LANES-1:0]      laneEn_o,
  output logic [CNT_W-1:0]      errCnt_o,
  output logic                  serBit_o,
  output logic [PRBS_ORDER-1:0] lfsrState_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRBS_ORDER-1:0] lfsr;
  logic                  feedback;
  logic [SEL_W-1:0]      laneReg;
  logic [LATENCY:0]      refPipe;
  logic                  refBit, mismatch;
  logic [CNT_W-1:0]      errCnt, errNext, shReg;

  // pattern generator, taps at stages 7 and 6
  assign feedback = lfsr[PRBS_ORDER-1] ^ lfsr[PRBS_ORDER-2];
  assign txBit_o  = ctrl_i.txEn ? lfsr[PRBS_ORDER-1] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lfsr <= SEED;
    else if (ctrl_i.load) lfsr <= SEED;
    else if (ctrl_i.txEn) lfsr <= {lfsr[PRBS_ORDER-2:0], feedback};
  end

  // reference delay so the sent bit meets its echo
  assign refPipe[0] = txBit_o;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) refPipe[LATENCY:1] <= '0;
    else         refPipe[LATENCY:1] <= refPipe[LATENCY-1:0];
  end
  assign refBit   = refPipe[LATENCY];
  assign mismatch = ctrl_i.cmpEn && (refBit ^ rxBit_i);

  // lane latch and one-hot enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          laneReg <= '0;
    else if (ctrl_i.load) laneReg <= laneSel_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneEn_o[g] = ctrl_i.laneOn && (laneReg == SEL_W'(g));
  end

  // saturating error counter
  always_comb begin
    errNext = errCnt;
    if (mismatch && (errCnt != CNT_MAX)) errNext = errCnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          errCnt <= '0;
    else if (ctrl_i.load) errCnt <= '0;
    else                  errCnt <= errNext;
  end

  // parallel to serial readout, MSB first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             shReg <= '0;
    else if (ctrl_i.load)    shReg <= '0;
    else if (ctrl_i.lastCmp) shReg <= errNext;
    else if (ctrl_i.shiftEn) shReg <= {shReg[CNT_W-2:0], 1'b0};
  end

  assign serBit_o    = ctrl_i.shiftEn ? shReg[CNT_W-1] : 1'b0;
  assign errCnt_o    = errCnt;
  assign lfsrState_o = lfsr;

endmodule

// File: rtl/prbs_bert.sv
module prbs_bert
  import prbs_bert_pkg::*;
#(
  parameter int unsigned           LANES   = 16,
  parameter int unsigned           PASSES  = 1,
  parameter int unsigned           LATENCY = 2,
  parameter int unsigned           CNT_W   = 8,
  parameter logic [PRBS_ORDER-1:0] SEED    = 7'h7F,
  localparam int unsigned          SEL_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] laneSel_i,
  input  logic             rxBit_i,
  output logic             txP_o,
  output logic             txN_o,
  output logic [LANES-1:0] laneEn_o,
  output logic             done_o,
  output logic [CNT_W-1:0] errCnt_o,
  output logic             serBit_o,
  output logic             serValid_o
);

  localparam int unsigned TOTAL_BITS = PRBS_PERIOD * PASSES;

  bertCtrl_t             ctrl;
  logic                  txBit;
  logic [PRBS_ORDER-1:0] lfsrState;

  bert_ctrl #(
    .TOTAL_BITS(TOTAL_BITS),
    .LATENCY   (LATENCY),
    .CNT_W     (CNT_W)
  ) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .ctrl_o (ctrl),
    .done_o (done_o)
  );

  bert_datapath #(
    .LANES  (LANES),
    .SEL_W  (SEL_W),
    .CNT_W  (CNT_W),
    .LATENCY(LATENCY),
    .SEED   (SEED)
  ) i_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .laneSel_i  (laneSel_i),
    .rxBit_i    (rxBit_i),
    .txBit_o    (txBit),
    .laneEn_o   (laneEn_o),
    .errCnt_o   (errCnt_o),
    .serBit_o   (serBit_o),
    .lfsrState_o(lfsrState)
  );

  assign txP_o      = txBit;
  assign txN_o      = ~txBit;
  assign serValid_o = ctrl.shiftEn;

endmodule

// File: rtl/bert_checker.sv
module bert_checker #(
  parameter int unsigned LANES = 16,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [6:0]       lfsrState,
  input logic [LANES-1:0] laneEn_o,
  input logic             done_o,
  input logic [CNT_W-1:0] errCnt_o,
  input logic             serValid_o
);

  // R1: generator never locks up in the zero state
  a_r1_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsrState != 7'd0);

  // R3: at most one lane enabled
  a_r3_lane_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(laneEn_o));

  // R4: enabled lane does not move during a run
  a_r4_lane_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((laneEn_o != '0) && !start_i) |=> ((laneEn_o == $past(laneEn_o)) || (laneEn_o == '0)));

  // R6: count cleared after start
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (errCnt_o == '0));

  // R6: count holds or steps by one, so it can never wrap
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (({1'b0, errCnt_o} == {1'b0, $past(errCnt_o)}) ||
                  ({1'b0, errCnt_o} == {1'b0, $past(errCnt_o)} + 9'd1)));

  // R7: done holds with a frozen count and the lane released
  a_r7_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(errCnt_o)));

  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (laneEn_o == '0));

  // R8: serial readout only while done
  a_r8_ser_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serValid_o |-> done_o);

endmodule

bind prbs_bert bert_checker #(.LANES(LANES), .CNT_W(CNT_W)) i_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .lfsrState (lfsrState),
  .laneEn_o  (laneEn_o),
  .done_o    (done_o),
  .errCnt_o  (errCnt_o),
  .serValid_o(serValid_o)
);

// File: tb/test_prbs_bert.sv
`timescale 1ns/1ps
module test_prbs_bert;

  localparam int LANES   = 16;
  localparam int PASSES  = 3;
  localparam int LAT     = 3;
  localparam int CNT_W   = 8;
  localparam int NBITS   = 127 * PASSES;
  localparam int RUNLEN  = NBITS + LAT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [3:0] laneSel = '0;
  logic rxBit = 1'b0;
  logic txP, txN, done, serBit, serValid;
  logic [LANES-1:0] laneEn;
  logic [CNT_W-1:0] errCnt;

  prbs_bert #(.LANES(LANES), .PASSES(PASSES), .LATENCY(LAT), .CNT_W(CNT_W)) i_prbs_bert (
    .clk_i(clk), .rst_ni(rstN), .start_i(startPulse), .laneSel_i(laneSel),
    .rxBit_i(rxBit), .txP_o(txP), .txN_o(txN), .laneEn_o(laneEn),
    .done_o(done), .errCnt_o(errCnt), .serBit_o(serBit), .serValid_o(serValid));

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 run, 2 shift, 3 done
  int mPhase = 0;
  int mK = 0;
  int mJ = 0;
  int mLane = 0;
  int mCnt = 0;
  bit [6:0] mGen = 7'h7F;
  bit mHist[$];
  bit armed = 0;

  int flipEvery = 0;
  bit flipAll = 0;

  function automatic bit flipAt(int idx);
    return flipAll || (flipEvery != 0 && (idx % flipEvery) == 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mK = 0; mJ = 0;
    end else if (startPulse) begin
      mPhase = 1; mK = 0; mGen = 7'h7F; mLane = int'(laneSel); mCnt = 0;
      mHist.delete();
    end else begin
      case (mPhase)
        1: begin
          if (mK < NBITS) begin
            mHist.push_back(mGen[6]);
            mGen = {mGen[5:0], mGen[6] ^ mGen[5]};
          end
          if (mK >= LAT && rxBit != mHist[mK-LAT] && mCnt < 255) mCnt++;
          if (mK == RUNLEN - 1) begin mPhase = 2; mJ = 0; end
          else mK++;
        end
        2: if (mJ == CNT_W - 1) mPhase = 3; else mJ++;
        default: ;
      endcase
    end
    armed = 1;
  end

  // per-cycle comparison and channel model
  always @(negedge clk) begin
    if (armed) begin
      bit expTx;
      int expLane;
      expTx = (mPhase == 1 && mK < NBITS) ? mGen[6] : 1'b0;
      expLane = (mPhase == 1) ? (1 << mLane) : 0;
      check(txP == expTx, "R1 txP bit", int'(txP), int'(expTx));
      check(txN == !expTx, "R2 txN complement", int'(txN), int'(!expTx));
      check(int'(laneEn) == expLane, "R3 lane enable", int'(laneEn), expLane);
      check(done == (mPhase >= 2), "R7 done flag", int'(done), int'(mPhase >= 2));
      check(serValid == (mPhase == 2), "R8 serial valid", int'(serValid), int'(mPhase == 2));
      check(int'(errCnt) == mCnt, "R5 running count", int'(errCnt), mCnt);
      if (mPhase == 2)
        check(serBit == mCnt[CNT_W-1-mJ], "R8 serial bit", int'(serBit), int'(mCnt[CNT_W-1-mJ]));
    end
    // returned bit; ignored cycles carry a 1 to show they do not count (R5)
    if (mPhase == 1 && mK >= LAT && mK - LAT < NBITS)
      rxBit = mHist.size() > mK - LAT ? mHist[mK-LAT] ^ flipAt(mK - LAT) : 1'b1;
    else
      rxBit = 1'b1;
  end

  // the rx for cycle k needs bit k-LAT, which is in mHist once k > k-LAT: always true

  task automatic kick(int lane, int every, bit all);
    @(negedge clk);
    laneSel = 4'(lane); flipEvery = every; flipAll = all; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitDone();
    while (mPhase != 3) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int expCount();
    int c = 0;
    for (int i = 0; i < NBITS; i++) if (flipAt(i) && c < 255) c++;
    return c;
  endfunction

  task automatic checkPattern();
    bit ok = 1;
    for (int i = 127; i < mHist.size(); i++) if (mHist[i] != mHist[i-127]) ok = 0;
    check(mHist.size() == NBITS, "R1 pattern length", mHist.size(), NBITS);
    check(ok, "R1 period 127", int'(ok), 1);
    check(mHist[0] == 1'b1, "R1 first bit from seed", int'(mHist[0]), 1);
  endtask

  task automatic finishRun(string tag, int lane);
    int e;
    e = expCount();
    waitDone();
    check(int'(errCnt) == e, tag, int'(errCnt), e);
    check(done == 1'b1 && laneEn == '0, "R7 done after run", int'(done), 1);
    checkPattern();
    lane = lane;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txP == 1'b0 && txN == 1'b1, "R10 reset drive pair", int'(txN), 1);
    check(laneEn == '0 && done == 1'b0 && serValid == 1'b0, "R10 reset flags", int'(laneEn), 0);
    check(errCnt == '0, "R10 reset count", int'(errCnt), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // clean loopback on lane 5
    kick(5, 0, 0);
    check(errCnt == '0 && laneEn == 16'h0020, "R6 clear and R3 lane 5", int'(laneEn), 32);
    finishRun("R5 clean run count", 5);

    // sparse errors on lane 0
    kick(0, 10, 0);
    finishRun("R5 every-tenth count", 0);

    // every bit wrong on lane 15, lane select moved mid-run
    kick(15, 0, 1);
    repeat (100) @(negedge clk);
    laneSel = 4'd2;
    @(negedge clk);
    check(laneEn == 16'h8000, "R4 lane change ignored", int'(laneEn), 32768);
    finishRun("R6 saturation count", 15);
    check(errCnt == 8'hFF, "R6 saturated at 255", int'(errCnt), 255);

    // done holds until the next start
    repeat (20) @(negedge clk);
    check(done == 1'b1 && errCnt == 8'hFF, "R7 done held", int'(errCnt), 255);

    // restart in the middle of a run
    kick(3, 0, 1);
    repeat (50) @(negedge clk);
    check(errCnt != '0, "R9 first run counting", int'(errCnt), 1);
    kick(9, 7, 0);
    check(errCnt == '0 && laneEn == 16'h0200, "R9 restart clears", int'(errCnt), 0);
    finishRun("R9 restarted run count", 9);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nFails, nChecks);
      $finish;
    end
  end

endmodule